// File: doc/BRIEF.md
# Three-Input Bitwise Truth-Table Unit with Lane Write Masking

The block takes three packed vector operands and an 8-bit truth table. It applies one arbitrary three-input Boolean function to every bit position. The three operand bits at a position form a 3-bit index. The result bit at that position is the truth-table bit at that index. The operation has no element width of its own.

A per-lane write mask then decides which lanes take the computed value. A lane is 32 or 64 bits wide, chosen per request. Lanes the mask leaves out are either cleared or keep the previous destination value; in this block the first operand supplies that previous value. The result is registered and appears one cycle after a valid request.

Instruction decode and register-file access sit outside the block. The vector width is a parameter and must be a multiple of 64; it is 128 by default.

Top module: `ternlog_unit`

## Requirements
- R1: For every bit position i, the function result is `tt_imm[idx]` with idx = 4*opa[i] + 2*opb[i] + opc[i]; opa supplies the index MSB and opc the LSB.
- R2: With tt_imm = 0x80 the function result is opa & opb & opc. With tt_imm = 0xFE it is opa | opb | opc.
- R3: With tt_imm = 0xCA, each function result bit equals opb where opa is 1 and opc where opa is 0.
- R4: With wide_lanes = 0, mask bit k governs result bits [32k+31:32k].
- R5: With wide_lanes = 1, mask bit j governs result bits [64j+63:64j]. Mask bits j >= VEC_W/64 are ignored in this mode.
- R6: With zero_fill = 1, every lane whose mask bit is 0 reads as all zeros.
- R7: With zero_fill = 0, every lane whose mask bit is 0 reads as the matching bits of opa.
- R8: With every governing mask bit set, the result equals the unmasked function result, whatever zero_fill is.
- R9: out_valid is 1 exactly in the cycle after a cycle with in_valid = 1, and result holds that request's value in that cycle.
- R10: While in_valid is 0, result keeps its last value.
- R11: After reset, out_valid and result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request valid this cycle |
| opa | input | VEC_W | First operand; index MSB and merge source |
| opb | input | VEC_W | Second operand; index middle bit |
| opc | input | VEC_W | Third operand; index LSB |
| tt_imm | input | 8 | Truth table of the bitwise function |
| lane_mask | input | VEC_W/32 | Per-lane write mask, bit k = lane k |
| wide_lanes | input | 1 | 0 = 32-bit lanes, 1 = 64-bit lanes |
| zero_fill | input | 1 | 1 = clear unselected lanes, 0 = keep opa |
| out_valid | output | 1 | Result valid |
| result | output | VEC_W | Registered masked result |

## Verification
The bench builds the unit with VEC_W = 64. This gives two 32-bit lanes and a single 64-bit lane, whose unused upper mask bit can be driven to show it is ignored. At this size the bench can sweep all 256 truth tables against every mask value, both lane sizes and both fill modes. One operand set puts all eight index combinations in every byte, so each truth table is visible in full; a pseudo-random operand set is run as well.

// File: rtl/tl_pkg.sv
// Shared definitions for the three-input truth-table unit.
// Assumes vector widths are multiples of the wide lane size.
package tl_pkg;
    typedef enum logic {
        LANE_32 = 1'b0,
        LANE_64 = 1'b1
    } lane_sz_e;

    localparam int NARROW_LANE_W = 32;
    localparam int WIDE_LANE_W   = 64;
endpackage

// File: rtl/tl_bitfunc.sv
// Bitwise three-input function: each output bit looks up the 8-bit truth
// table at the index built from the three operand bits (a is the MSB).
// Assumes nothing about lanes; purely combinational.
module tl_bitfunc #(
    parameter int W = 128
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    input  logic [7:0]   tt,
    output logic [W-1:0] fn_bits
);
    // One 8:1 lookup per bit position.
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign fn_bits[g] = tt[{op_a[g], op_b[g], op_c[g]}];
    end
endmodule

// File: rtl/tl_lane_enable.sv
// Expands the per-lane mask into a per-bit write enable at 32- or 64-bit
// granularity. Assumes W is a multiple of 64; in 64-bit mode mask bits
// at or above W/64 are not consulted.
module tl_lane_enable
    import tl_pkg::*;
#(
    parameter int W = 128,
    localparam int MASK_W = W / NARROW_LANE_W
) (
    input  logic [MASK_W-1:0] lane_mask,
    input  lane_sz_e          lane_sz,
    output logic [W-1:0]      bit_en
);
    // Each bit picks the mask bit of the lane it belongs to.
    for (genvar g = 0; g < W; g++) begin : g_en
        assign bit_en[g] = (lane_sz == LANE_64) ? lane_mask[g / WIDE_LANE_W]
                                                : lane_mask[g / NARROW_LANE_W];
    end
endmodule

// File: rtl/tl_mask_merge.sv
// Applies the write enable: enabled bits take the function result, the
// others become zero or the merge source. Purely combinational.
module tl_mask_merge #(
    parameter int W = 128
) (
    input  logic [W-1:0] fn_bits,
    input  logic [W-1:0] merge_src,
    input  logic [W-1:0] bit_en,
    input  logic         zero_fill,
    output logic [W-1:0] masked
);
    logic [W-1:0] fill_bits;

    // Value used for bits outside the mask.
    always_comb fill_bits = zero_fill ? '0 : merge_src;

    // Bitwise select between function result and fill.
    always_comb masked = (fn_bits & bit_en) | (fill_bits & ~bit_en);
endmodule

// File: rtl/ternlog_unit.sv
// Three-input bitwise truth-table unit with per-lane write masking and a
// registered output one cycle after in_valid. Assumes VEC_W is a multiple
// of 64. The merge source (previous destination) is operand a.
module ternlog_unit
    import tl_pkg::*;
#(
    parameter int VEC_W = 128,
    localparam int MASK_W = VEC_W / NARROW_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  opa,
    input  logic [VEC_W-1:0]  opb,
    input  logic [VEC_W-1:0]  opc,
    input  logic [7:0]        tt_imm,
    input  logic [MASK_W-1:0] lane_mask,
    input  logic              wide_lanes,
    input  logic              zero_fill,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result
);
    logic [VEC_W-1:0] fn_bits;
    logic [VEC_W-1:0] bit_en;
    logic [VEC_W-1:0] masked;
    lane_sz_e         lane_sz;

    // Map the lane-size pin onto the enum.
    always_comb lane_sz = wide_lanes ? LANE_64 : LANE_32;

    tl_bitfunc #(.W(VEC_W)) i_bitfunc (
        .op_a    (opa),
        .op_b    (opb),
        .op_c    (opc),
        .tt      (tt_imm),
        .fn_bits (fn_bits)
    );

    tl_lane_enable #(.W(VEC_W)) i_lane_enable (
        .lane_mask (lane_mask),
        .lane_sz   (lane_sz),
        .bit_en    (bit_en)
    );

    tl_mask_merge #(.W(VEC_W)) i_mask_merge (
        .fn_bits   (fn_bits),
        .merge_src (opa),
        .bit_en    (bit_en),
        .zero_fill (zero_fill),
        .masked    (masked)
    );

    // Output register: capture on a valid request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= masked;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R9
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R9
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));  // R10
    AST_ALL_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_fill && lane_mask == '0) |=> (result == '0));  // R6
    AST_MERGE_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zero_fill && lane_mask == '0) |=> (result == $past(opa)));  // R7
    AST_TABLE_A_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&lane_mask) && tt_imm == 8'hF0) |=> (result == $past(opa)));  // R1
endmodule

// File: tb/test_ternlog_unit.sv
module test_ternlog_unit;
    localparam int W  = 64;
    localparam int MW = W / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  opa = '0, opb = '0, opc = '0;
    logic [7:0]    tt_imm = '0;
    logic [MW-1:0] lane_mask = '0;
    logic          wide_lanes = 1'b0, zero_fill = 1'b0;
    logic          out_valid;
    logic [W-1:0]  result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    ternlog_unit #(.VEC_W(W)) i_ternlog_unit (
        .clk, .rst_n, .in_valid, .opa, .opb, .opc, .tt_imm,
        .lane_mask, .wide_lanes, .zero_fill, .out_valid, .result
    );

    always #10 clk = ~clk;  // 50 MHz

    // Expected value from the requirements: per-bit table lookup, then lanes.
    function automatic logic [W-1:0] model(input logic [W-1:0] a, b, c,
                                           input logic [7:0] imm,
                                           input logic [MW-1:0] m,
                                           input logic wide, zf);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int idx = 4 * int'(a[i]) + 2 * int'(b[i]) + int'(c[i]);
            logic en = wide ? m[i / 64] : m[i / 32];
            r[i] = en ? imm[idx] : (zf ? 1'b0 : a[i]);
        end
        return r;
    endfunction

    function automatic logic [W-1:0] xs(input logic [W-1:0] s);
        logic [W-1:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request, sample at the falling edge after it is captured.
    task automatic issue(input logic [W-1:0] a, b, c, input logic [7:0] imm,
                         input logic [MW-1:0] m, input logic wide, zf,
                         input string tag, input bit idle_check);
        logic [W-1:0] exp;
        @(negedge clk);
        opa = a; opb = b; opc = c; tt_imm = imm;
        lane_mask = m; wide_lanes = wide; zero_fill = zf; in_valid = 1'b1;
        exp = model(a, b, c, imm, m, wide, zf);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R9 valid"}, {63'd0, out_valid}, 64'd1);
        check(tag, result, exp);
        if (idle_check) begin
            opa = ~a; opb = ~b; opc = ~c; tt_imm = ~imm; zero_fill = ~zf;
            @(negedge clk);
            check("R9 valid low", {63'd0, out_valid}, 64'd0);
            check("R10 hold", result, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] ra, rb, rc;
        logic [W-1:0] ta, tb, tc;
        ta = {8{8'hF0}}; tb = {8{8'hCC}}; tc = {8{8'hAA}};
        ra = 64'h1234_5678_9ABC_DEF1;
        repeat (3) @(negedge clk);
        check("R11 valid", {63'd0, out_valid}, 64'd0);
        check("R11 result", result, 64'd0);
        rst_n = 1'b1;

        // R1 truth table visible per byte with all-ones mask
        for (int imm = 0; imm < 256; imm++)
            issue(ta, tb, tc, imm[7:0], '1, 1'b0, 1'b1, "R1 R8", imm % 32 == 0);

        // R2 and R3 against direct Boolean formulas
        rb = xs(ra); rc = xs(rb);
        issue(ra, rb, rc, 8'h80, '1, 1'b0, 1'b0, "R2 and", 1'b0);
        check("R2 and formula", result, ra & rb & rc);
        issue(ra, rb, rc, 8'hFE, '1, 1'b1, 1'b0, "R2 or", 1'b0);
        check("R2 or formula", result, ra | rb | rc);
        issue(ra, rb, rc, 8'hCA, '1, 1'b0, 1'b1, "R3 select", 1'b0);
        check("R3 select formula", result, (ra & rb) | (~ra & rc));

        // R4 R5 R6 R7: full sweep of masks, lane sizes, fill modes
        for (int imm = 0; imm < 256; imm++)
            for (int m = 0; m < (1 << MW); m++)
                for (int wd = 0; wd < 2; wd++)
                    for (int z = 0; z < 2; z++) begin
                        string tag;
                        tag = $sformatf("%s %s imm=%0d m=%0d",
                                        wd ? "R5" : "R4", z ? "R6" : "R7", imm, m);
                        issue(ta, tb, tc, imm[7:0], m[MW-1:0], wd[0], z[0], tag, 1'b0);
                        ra = xs(ra); rb = xs(ra); rc = xs(rb);
                        issue(ra, rb, rc, imm[7:0], m[MW-1:0], wd[0], z[0], tag,
                              (imm % 16) == 0);
                    end

        // R5 ignored upper mask bit in 64-bit mode: merge keeps opa entirely
        issue(ra, rb, rc, 8'h00, 2'b10, 1'b1, 1'b0, "R5 upper bit ignored", 1'b0);
        check("R5 upper bit ignored direct", result, ra);
        // R4 lane split in 32-bit mode, zero fill
        issue({8{8'hFF}}, '0, '0, 8'hFF, 2'b10, 1'b0, 1'b1, "R4 split", 1'b0);
        check("R4 split direct", result, 64'hFFFF_FFFF_0000_0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule